// File: doc/BRIEF.md
# Power-Up Reset Sequencer

This block brings a power-management device from its off state to normal operation after a wake request. Four single-bit wake requests are accepted, but only while the block is off: a power key, a charger detection, an alarm expiry and the release of a master reset. After a wake request, the block waits through a fixed delay and then enters its reset phase. A settling delay starts only once the battery comparator reports a voltage above the cut-off level.

Supplies then come up in two stages. The first flash supply switches on alone. After a short gap, a group of four supplies (core, I/O, analog and auxiliary) switches on together. The active-low system reset output is held low for one more delay and then released. Through the whole reset phase, the oscillator supply enable is forced high, whatever the sleep request says.

A supervisory watchdog runs from the start of the reset phase. If it expires, the block returns to off and drops every enable. The watchdog is restarted on the release edge of the system reset, so software always gets the full timeout. In the running state, software keeps it alive with a kick input. All delays are counted in ticks of a slow timebase input (nominally 100 µs per tick), and their lengths are parameters.

Top module: `pwrup_seq`

## Requirements
- R1: After reset, and after any reset applied mid-sequence, the block is off: `state_o` is 0, every enable is 0, `sys_rst_n` is 0 and `run_pulse` is 0.
- R2: While off (code 0), any of `wake_key`, `wake_chg`, `wake_alarm`, `wake_mrst` being 1 at a clock edge moves the block to the wake delay (code 1). In any other state, wake inputs have no effect on the state or on delay timing.
- R3: The wake delay lasts exactly `T_WAKE` tick pulses. The tick that completes it moves the block to the reset phase (code 2).
- R4: In the reset phase (code 2), the block stays while `batt_ok` is 0. At the first edge with `batt_ok` at 1, it moves to settling (code 3).
- R5: Settling lasts `T_SETTLE` ticks. Its last tick moves the block to code 4 and sets `en_flash1` to 1.
- R6: `T_GAP` ticks after entering code 4, all four bits of `en_grp` (bit 3 core, bit 2 I/O, bit 1 analog, bit 0 auxiliary) go to 1 together, and the state becomes code 5. `en_flash1` stays 1.
- R7: `sys_rst_n` stays 0 until the `T_HOLD`-th tick in code 5. That tick moves the block to running (code 6), sets `sys_rst_n` to 1 and raises `run_pulse` for exactly one cycle.
- R8: `en_osc` is 1 in codes 2 to 5 regardless of `sleep_req`. It equals `!sleep_req` in code 6 and is 0 in codes 0 and 1.
- R9: The watchdog counts ticks from entry into code 2. On its `WDOG_TICKS`-th tick without a restart, the block returns to code 0 with all enables off.
- R10: The watchdog restarts in the cycle after `sys_rst_n` rises, so running gets a full `WDOG_TICKS` ticks.
- R11: In code 6, `wdog_kick` restarts the watchdog. A kick in the same cycle as the expiring tick wins, and the block stays running.
- R12: `en_sim` equals `sw_sim_en` and `en_flash2` equals `sw_flash2_en` in code 6 only. In every other state, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse of the slow timebase |
| wake_key | input | 1 | Power key wake request |
| wake_chg | input | 1 | Charger detected wake request |
| wake_alarm | input | 1 | Alarm expiry wake request |
| wake_mrst | input | 1 | Master reset released wake request |
| batt_ok | input | 1 | Battery above cut-off comparator flag |
| sleep_req | input | 1 | Sleep request for the oscillator supply |
| sw_sim_en | input | 1 | Software enable for the SIM supply |
| sw_flash2_en | input | 1 | Software enable for the second flash supply |
| wdog_kick | input | 1 | Software watchdog acknowledge |
| en_flash1 | output | 1 | First flash supply enable |
| en_grp | output | 4 | Core, I/O, analog, auxiliary supply enables |
| en_osc | output | 1 | Oscillator supply enable |
| en_sim | output | 1 | SIM supply enable |
| en_flash2 | output | 1 | Second flash supply enable |
| sys_rst_n | output | 1 | Active-low system reset |
| state_o | output | 3 | Encoded sequencer state |
| run_pulse | output | 1 | One-cycle pulse on reaching running |

## Verification
A software kick can land in the same cycle as the watchdog's expiring tick. The bench lets exactly `WDOG_TICKS-1` ticks pass in running and then presents the next tick together with `wdog_kick`. It judges that the block stays running, and that a later full unkicked period still returns it to off. A watchdog expiry can also compete with the wait for `batt_ok` in the reset phase. The bench holds `batt_ok` low and checks that the state stays at code 2 until the exact expiring tick, then drops to off.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_WAKE   = 3'd1,
        ST_RESET  = 3'd2,
        ST_SETTLE = 3'd3,
        ST_FLASH  = 3'd4,
        ST_HOLD   = 3'd5,
        ST_RUN    = 3'd6
    } pstate_e;

    typedef struct packed {
        pstate_e state;
        logic    run_pulse;
    } seq_regs_t;

endpackage

// File: rtl/pwrup_tick_timer.sv
module pwrup_tick_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        done = tick && (cnt_q == limit - 1'b1);
        if (clr)       cnt_d = '0;
        else if (tick) cnt_d = cnt_q + 1'b1;
        else           cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // a cleared delay restarts from zero (R3, R5, R6, R7)
    assert_clr_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);

endmodule

// File: rtl/pwrup_wdog.sv
module pwrup_wdog #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic restart,
    input  logic tick,
    output logic bite
);
    localparam int unsigned W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        bite = active && tick && !restart && (cnt_q == W'(LIMIT - 1));
        if (!active || restart) cnt_d = '0;
        else if (tick)          cnt_d = cnt_q + 1'b1;
        else                    cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_restart_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> cnt_q == '0);

    assert_idle_no_bite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt_q == '0) && !bite);

endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
    import pwrup_pkg::*;
#(
    parameter int unsigned T_WAKE     = 200,
    parameter int unsigned T_SETTLE   = 2000,
    parameter int unsigned T_GAP      = 5,
    parameter int unsigned T_HOLD     = 200,
    parameter int unsigned WDOG_TICKS = 320000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wake_key,
    input  logic       wake_chg,
    input  logic       wake_alarm,
    input  logic       wake_mrst,
    input  logic       batt_ok,
    input  logic       sleep_req,
    input  logic       sw_sim_en,
    input  logic       sw_flash2_en,
    input  logic       wdog_kick,
    output logic       en_flash1,
    output logic [3:0] en_grp,
    output logic       en_osc,
    output logic       en_sim,
    output logic       en_flash2,
    output logic       sys_rst_n,
    output logic [2:0] state_o,
    output logic       run_pulse
);
    localparam int unsigned TMAX_A = (T_WAKE > T_SETTLE) ? T_WAKE : T_SETTLE;
    localparam int unsigned TMAX_B = (T_GAP > T_HOLD) ? T_GAP : T_HOLD;
    localparam int unsigned TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
    localparam int unsigned TW     = $clog2(TMAX + 1);

    seq_regs_t     seq_d, seq_q;
    logic          any_wake;
    logic          tmr_clr, tmr_done, timed;
    logic [TW-1:0] tmr_limit;
    logic          wd_active, wd_restart, wd_bite;
    logic          in_reset_phase;

    assign any_wake = wake_key | wake_chg | wake_alarm | wake_mrst;

    // delay length for the current timed state
    always_comb begin
        timed     = 1'b1;
        tmr_limit = TW'(1);
        case (seq_q.state)
            ST_WAKE:   tmr_limit = TW'(T_WAKE);
            ST_SETTLE: tmr_limit = TW'(T_SETTLE);
            ST_FLASH:  tmr_limit = TW'(T_GAP);
            ST_HOLD:   tmr_limit = TW'(T_HOLD);
            default:   timed     = 1'b0;
        endcase
    end

    // next-state process
    always_comb begin
        seq_d           = seq_q;
        seq_d.run_pulse = 1'b0;
        if (wd_bite) begin
            seq_d.state = ST_OFF;
        end else begin
            case (seq_q.state)
                ST_OFF:    if (any_wake) seq_d.state = ST_WAKE;
                ST_WAKE:   if (tmr_done) seq_d.state = ST_RESET;
                ST_RESET:  if (batt_ok)  seq_d.state = ST_SETTLE;
                ST_SETTLE: if (tmr_done) seq_d.state = ST_FLASH;
                ST_FLASH:  if (tmr_done) seq_d.state = ST_HOLD;
                ST_HOLD: begin
                    if (tmr_done) begin
                        seq_d.state     = ST_RUN;
                        seq_d.run_pulse = 1'b1;
                    end
                end
                ST_RUN:    seq_d.state = ST_RUN;
                default:   seq_d.state = ST_OFF;
            endcase
        end
        tmr_clr = (seq_d.state != seq_q.state) || !timed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: ST_OFF, run_pulse: 1'b0};
        else        seq_q <= seq_d;
    end

    pwrup_tick_timer #(.W(TW)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .tick  (tick),
        .limit (tmr_limit),
        .done  (tmr_done)
    );

    assign wd_active  = (seq_q.state != ST_OFF) && (seq_q.state != ST_WAKE);
    assign wd_restart = seq_q.run_pulse || ((seq_q.state == ST_RUN) && wdog_kick);

    pwrup_wdog #(.LIMIT(WDOG_TICKS)) i_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (wd_active),
        .restart (wd_restart),
        .tick    (tick),
        .bite    (wd_bite)
    );

    // output decode
    always_comb begin
        in_reset_phase = (seq_q.state == ST_RESET) || (seq_q.state == ST_SETTLE) ||
                         (seq_q.state == ST_FLASH) || (seq_q.state == ST_HOLD);
        en_flash1 = (seq_q.state == ST_FLASH) || (seq_q.state == ST_HOLD) ||
                    (seq_q.state == ST_RUN);
        en_grp    = {4{(seq_q.state == ST_HOLD) || (seq_q.state == ST_RUN)}};
        sys_rst_n = (seq_q.state == ST_RUN);
        if (in_reset_phase)              en_osc = 1'b1;
        else if (seq_q.state == ST_RUN)  en_osc = !sleep_req;
        else                             en_osc = 1'b0;
        en_sim    = (seq_q.state == ST_RUN) && sw_sim_en;
        en_flash2 = (seq_q.state == ST_RUN) && sw_flash2_en;
        state_o   = seq_q.state;
        run_pulse = seq_q.run_pulse;
    end

    assert_bite_to_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wd_bite |=> (state_o == 3'd0) && (en_flash1 == 1'b0) && (en_grp == 4'd0));

    assert_off_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_OFF) && !any_wake |=> seq_q.state == ST_OFF);

    assert_wait_battery_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_RESET) && !batt_ok && !wd_bite |=> seq_q.state == ST_RESET);

    assert_group_after_flash_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_grp[0]) |-> $past(en_flash1) && (en_grp == 4'hF));

    assert_release_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> run_pulse && ($past(seq_q.state) == ST_HOLD));

    assert_osc_forced_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_reset_phase |-> en_osc);

endmodule

// File: tb/test_pwrup_seq.sv
module test_pwrup_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WD = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wake_key = 1'b0, wake_chg = 1'b0, wake_alarm = 1'b0, wake_mrst = 1'b0;
    logic       batt_ok = 1'b0, sleep_req = 1'b0;
    logic       sw_sim_en = 1'b1, sw_flash2_en = 1'b1, wdog_kick = 1'b0;
    logic       en_flash1, en_osc, en_sim, en_flash2, sys_rst_n, run_pulse;
    logic [3:0] en_grp;
    logic [2:0] state_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrup_seq #(
        .T_WAKE(3), .T_SETTLE(4), .T_GAP(2), .T_HOLD(3), .WDOG_TICKS(WD)
    ) i_pwrup_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .wake_key(wake_key), .wake_chg(wake_chg), .wake_alarm(wake_alarm),
        .wake_mrst(wake_mrst), .batt_ok(batt_ok), .sleep_req(sleep_req),
        .sw_sim_en(sw_sim_en), .sw_flash2_en(sw_flash2_en), .wdog_kick(wdog_kick),
        .en_flash1(en_flash1), .en_grp(en_grp), .en_osc(en_osc), .en_sim(en_sim),
        .en_flash2(en_flash2), .sys_rst_n(sys_rst_n), .state_o(state_o),
        .run_pulse(run_pulse)
    );

    // {wake key,chg,alarm,mrst; batt; sleep; tick; kick; state[3]; rst_n; flash1; grp; osc; pulse}
    localparam logic [15:0] VECS [0:15] = '{
        {4'b0100, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {4'b1000, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {4'b0000, 1'b1, 1'b1, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {4'b0001, 1'b1, 1'b1, 1'b1, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 3'd4, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        {4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 3'd4, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        {4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 3'd5, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 3'd5, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 3'd5, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 3'd6, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
        {4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 3'd6, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // one clock with the given tick value; returns just after the edge
    task automatic cyc(input logic t);
        tick = t;
        @(posedge clk);
        #1;
        tick = 1'b0;
    endtask

    task automatic all_off(input string req);
        check(req, {28'd0, en_flash1, en_osc, en_sim, en_flash2}, 32'd0);
        check(req, {28'd0, en_grp}, 32'd0);
        check(req, {31'd0, sys_rst_n}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 state", {29'd0, state_o}, 32'd0);
        all_off("R1 outputs");
        check("R1 pulse", {31'd0, run_pulse}, 32'd0);
        rst_n = 1'b1;
        cyc(1'b0);
        check("R2 no wake stays off", {29'd0, state_o}, 32'd0);

        // R2..R8, R12: nominal power-up walk
        for (int i = 0; i < 16; i++) begin
            {wake_key, wake_chg, wake_alarm, wake_mrst} = VECS[i][15:12];
            batt_ok   = VECS[i][11];
            sleep_req = VECS[i][10];
            wdog_kick = VECS[i][8];
            cyc(VECS[i][9]);
            check("R2 R3 R4 R5 state", {29'd0, state_o}, {29'd0, VECS[i][7:5]});
            check("R7 sys_rst_n", {31'd0, sys_rst_n}, {31'd0, VECS[i][4]});
            check("R5 en_flash1", {31'd0, en_flash1}, {31'd0, VECS[i][3]});
            check("R6 en_grp", {28'd0, en_grp}, {28'd0, {4{VECS[i][2]}}});
            check("R8 en_osc", {31'd0, en_osc}, {31'd0, VECS[i][1]});
            check("R7 run_pulse", {31'd0, run_pulse}, {31'd0, VECS[i][0]});
            check("R12 en_sim", {31'd0, en_sim}, {31'd0, VECS[i][7:5] == 3'd6});
            check("R12 en_flash2", {31'd0, en_flash2}, {31'd0, VECS[i][7:5] == 3'd6});
        end
        wake_key = 1'b0; wake_chg = 1'b0; wake_alarm = 1'b0; wake_mrst = 1'b0;

        // R12 software bits follow in running
        sw_sim_en = 1'b0;
        #1;
        check("R12 sim follows sw", {31'd0, en_sim}, 32'd0);
        check("R12 flash2 follows sw", {31'd0, en_flash2}, 32'd1);
        sleep_req = 1'b1;
        #1;
        check("R8 osc follows sleep in run", {31'd0, en_osc}, 32'd0);
        sleep_req = 1'b0;

        // R10, R11: full period after release, kick on the expiring tick
        repeat (WD - 1) cyc(1'b1);
        check("R10 full period after release", {29'd0, state_o}, 32'd6);
        wdog_kick = 1'b1;
        cyc(1'b1);
        wdog_kick = 1'b0;
        check("R11 kick wins same cycle", {29'd0, state_o}, 32'd6);
        repeat (WD - 1) cyc(1'b1);
        check("R11 restarted by kick", {29'd0, state_o}, 32'd6);
        cyc(1'b1);
        check("R9 expiry in run", {29'd0, state_o}, 32'd0);
        all_off("R9 expiry drops enables");

        // R4, R9: battery never good, watchdog aborts
        wake_alarm = 1'b1;
        cyc(1'b0);
        wake_alarm = 1'b0;
        check("R2 alarm wakes", {29'd0, state_o}, 32'd1);
        check("R8 osc off in wake delay", {31'd0, en_osc}, 32'd0);
        batt_ok = 1'b0;
        sleep_req = 1'b1;
        repeat (3) cyc(1'b1);
        check("R3 reset phase", {29'd0, state_o}, 32'd2);
        check("R8 osc forced despite sleep", {31'd0, en_osc}, 32'd1);
        repeat (WD - 1) cyc(1'b1);
        check("R4 waits for battery", {29'd0, state_o}, 32'd2);
        cyc(1'b1);
        check("R9 abort from reset phase", {29'd0, state_o}, 32'd0);
        all_off("R9 abort drops enables");

        // R1 reset mid-sequence
        batt_ok = 1'b1;
        wake_mrst = 1'b1;
        cyc(1'b0);
        wake_mrst = 1'b0;
        check("R2 mrst wakes", {29'd0, state_o}, 32'd1);
        repeat (3) cyc(1'b1);
        cyc(1'b0);
        check("R4 battery good moves on", {29'd0, state_o}, 32'd3);
        rst_n = 1'b0;
        #2;
        check("R1 mid reset state", {29'd0, state_o}, 32'd0);
        all_off("R1 mid reset outputs");
        rst_n = 1'b1;
        cyc(1'b1);
        check("R1 stays off", {29'd0, state_o}, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule